// File: doc/BRIEF.md
# Port and Register Transfer Decoder

This block sits beside the instruction decoder of a small 4-bit core. It handles the instructions that move nibbles between the accumulator and the outside world. It can load the accumulator from input port S, input port M, status register 3 or the special function register. It can store the accumulator into control register 3 or into the special function register. It also holds the pull-down enables of ports S and M.

An issued instruction is presented with `valid_i` together with its opcode, a select bit and the current 4-bit pointer. Every result is registered, so the strobes and data for an instruction presented before clock edge k appear just after edge k. Control register 3 and the pull-down enables are updated on that same edge.

The select bit and the pointer decide whether a status or control transfer is legal. With select high, the transfer targets the special function register. With select low, only pointer value D is allowed. Any other pointer value raises the error pulse and blocks every write for that instruction.

Top module: `io_xfer_dec`

## Requirements
- R1: While `rst_ni` is low and after its release, `err_o`, `acc_we_o`, `sfr_we_o`, both write data buses, `ctl3_o` and both pull-down enables are 0.
- R2: Opcode 0xAF loads the accumulator from port S. In the next cycle `acc_we_o` is 1 and `acc_wdata_o` equals the `port_s_i` value sampled with the instruction.
- R3: Opcode 0xA8 loads the accumulator from port M in the same way, with the value taken from `port_m_i`.
- R4: Opcodes 0xF4 to 0xF7 (upper six bits 111101) load both pull-down enables. Opcode bit 0 sets the port S enable (1 = on) and opcode bit 1 sets the port M enable. The new values show on `pd_s_en_o` and `pd_m_en_o` after the edge.
- R5: IN (0x17) with `sel_i`=0 and `ptr_i`=0xD loads the accumulator from `sts3_i`.
- R6: OUT (0xFC) with `sel_i`=0 and `ptr_i`=0xD stores `acc_i` into control register 3, shown on `ctl3_o`. No accumulator or special register strobe is raised.
- R7: With `sel_i`=1 and any pointer value, IN loads the accumulator from `sfr_rd_i`. OUT pulses `sfr_we_o` with `sfr_wdata_o` equal to `acc_i`, and `ctl3_o` is left unchanged.
- R8: IN, OUT or the table-write opcode 0x02 issued with `sel_i`=0 and a pointer other than 0xD raises `err_o` for exactly that one cycle. In that cycle no strobe is raised and `ctl3_o` is unchanged.
- R9: NOP (0xFF), any unlisted opcode, or any cycle with `valid_i`=0 raises no strobe and no error, and leaves `ctl3_o` and the pull-down enables unchanged.
- R10: The table-write opcode 0x02 issued with a legal select and pointer raises no error and no strobe, because its ROM transfer is handled elsewhere.
- R11: While a strobe is low, its write data bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 8 | Instruction opcode |
| sel_i | input | 1 | Special-register select bit |
| ptr_i | input | 4 | Current pointer value |
| acc_i | input | 4 | Current accumulator value |
| port_s_i | input | 4 | Input port S |
| port_m_i | input | 4 | Input port M |
| sts3_i | input | 4 | Status register 3 contents |
| sfr_rd_i | input | 4 | Special function register read data |
| acc_we_o | output | 1 | Accumulator load strobe |
| acc_wdata_o | output | 4 | Accumulator load data |
| sfr_we_o | output | 1 | Special function register write strobe |
| sfr_wdata_o | output | 4 | Special function register write data |
| ctl3_o | output | 4 | Control register 3 |
| pd_s_en_o | output | 1 | Port S pull-down enable |
| pd_m_en_o | output | 1 | Port M pull-down enable |
| err_o | output | 1 | Illegal transfer pulse |

## Verification
The bench probes the pointer boundary around D. It checks 0, C, E and F with select low, where a decoder with a loose range compare would let a write through to control register 3 or leave the error silent. It then issues OUT with select high and checks that the special register strobe fires while control register 3 holds its value, which catches a design that writes to both destinations. It follows an illegal transfer with a NOP to show the error lasting only one cycle. It also sends an OUT with `valid_i` low and checks that nothing is written. Finally, it walks all four pull-down codes, which exposes swapped enable bits.

// File: rtl/io_xfer_pkg.sv
package io_xfer_pkg;

  localparam logic [7:0] OP_IPS  = 8'hAF;
  localparam logic [7:0] OP_IPM  = 8'hA8;
  localparam logic [7:0] OP_IN   = 8'h17;
  localparam logic [7:0] OP_OUT  = 8'hFC;
  localparam logic [7:0] OP_TWR  = 8'h02;
  localparam logic [5:0] OP_PD_HI = 6'b111101;

  typedef enum logic [1:0] {
    SRC_PS  = 2'd0,
    SRC_PM  = 2'd1,
    SRC_STS = 2'd2,
    SRC_SFR = 2'd3
  } acc_src_e;

  typedef struct packed {
    acc_src_e acc_src;
    logic     acc_we;
    logic     sfr_we;
    logic     ctl_we;
    logic     pd_we;
    logic     pd_s;
    logic     pd_m;
    logic     err;
  } xfer_ctl_t;

endpackage

// File: rtl/io_xfer_decode.sv
module io_xfer_decode
  import io_xfer_pkg::*;
#(
  parameter int unsigned PTR_W = 4,
  parameter logic [PTR_W-1:0] CTL_PTR = 4'hD
) (
  input  logic             valid_i,
  input  logic [7:0]       opcode_i,
  input  logic             sel_i,
  input  logic [PTR_W-1:0] ptr_i,
  output xfer_ctl_t        ctl_o
);

  logic legal;
  assign legal = sel_i || (ptr_i == CTL_PTR);

  always_comb begin
    ctl_o = '0;
    ctl_o.acc_src = SRC_PS;
    if (valid_i) begin
      if (opcode_i == OP_IPS) begin
        ctl_o.acc_we = 1'b1;
      end else if (opcode_i == OP_IPM) begin
        ctl_o.acc_we  = 1'b1;
        ctl_o.acc_src = SRC_PM;
      end else if (opcode_i[7:2] == OP_PD_HI) begin
        ctl_o.pd_we = 1'b1;
        ctl_o.pd_s  = opcode_i[0];
        ctl_o.pd_m  = opcode_i[1];
      end else if (opcode_i == OP_IN) begin
        if (!legal) ctl_o.err = 1'b1;
        else begin
          ctl_o.acc_we  = 1'b1;
          ctl_o.acc_src = sel_i ? SRC_SFR : SRC_STS;
        end
      end else if (opcode_i == OP_OUT) begin
        if (!legal) ctl_o.err = 1'b1;
        else if (sel_i) ctl_o.sfr_we = 1'b1;
        else ctl_o.ctl_we = 1'b1;
      end else if (opcode_i == OP_TWR) begin
        // ROM transfer lives elsewhere; only legality is checked here
        if (!legal) ctl_o.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/io_xfer_mux.sv
module io_xfer_mux
  import io_xfer_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  acc_src_e        src_i,
  input  logic [DW-1:0]   port_s_i,
  input  logic [DW-1:0]   port_m_i,
  input  logic [DW-1:0]   sts3_i,
  input  logic [DW-1:0]   sfr_rd_i,
  output logic [DW-1:0]   data_o
);

  always_comb begin
    unique case (src_i)
      SRC_PS:  data_o = port_s_i;
      SRC_PM:  data_o = port_m_i;
      SRC_STS: data_o = sts3_i;
      default: data_o = sfr_rd_i;
    endcase
  end

endmodule

// File: rtl/io_xfer_regs.sv
module io_xfer_regs
  import io_xfer_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_ctl_t     ctl_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_wdata_o,
  output logic          sfr_we_o,
  output logic [DW-1:0] sfr_wdata_o,
  output logic [DW-1:0] ctl3_o,
  output logic          pd_s_en_o,
  output logic          pd_m_en_o,
  output logic          err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_we_o    <= 1'b0;
      acc_wdata_o <= '0;
      sfr_we_o    <= 1'b0;
      sfr_wdata_o <= '0;
      ctl3_o      <= '0;
      pd_s_en_o   <= 1'b0;
      pd_m_en_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      acc_we_o    <= ctl_i.acc_we;
      acc_wdata_o <= ctl_i.acc_we ? ld_data_i : '0;
      sfr_we_o    <= ctl_i.sfr_we;
      sfr_wdata_o <= ctl_i.sfr_we ? acc_i : '0;
      err_o       <= ctl_i.err;
      if (ctl_i.ctl_we) ctl3_o <= acc_i;
      if (ctl_i.pd_we) begin
        pd_s_en_o <= ctl_i.pd_s;
        pd_m_en_o <= ctl_i.pd_m;
      end
    end
  end

endmodule

// File: rtl/io_xfer_dec.sv
module io_xfer_dec
  import io_xfer_pkg::*;
#(
  parameter int unsigned DW = 4,
  parameter int unsigned PTR_W = 4,
  parameter logic [PTR_W-1:0] CTL_PTR = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       opcode_i,
  input  logic             sel_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [DW-1:0]    acc_i,
  input  logic [DW-1:0]    port_s_i,
  input  logic [DW-1:0]    port_m_i,
  input  logic [DW-1:0]    sts3_i,
  input  logic [DW-1:0]    sfr_rd_i,
  output logic             acc_we_o,
  output logic [DW-1:0]    acc_wdata_o,
  output logic             sfr_we_o,
  output logic [DW-1:0]    sfr_wdata_o,
  output logic [DW-1:0]    ctl3_o,
  output logic             pd_s_en_o,
  output logic             pd_m_en_o,
  output logic             err_o
);

  xfer_ctl_t     ctl;
  logic [DW-1:0] ld_data;

  io_xfer_decode #(.PTR_W(PTR_W), .CTL_PTR(CTL_PTR)) u_dec (
    .valid_i (valid_i),
    .opcode_i(opcode_i),
    .sel_i   (sel_i),
    .ptr_i   (ptr_i),
    .ctl_o   (ctl)
  );

  io_xfer_mux #(.DW(DW)) u_mux (
    .src_i   (ctl.acc_src),
    .port_s_i(port_s_i),
    .port_m_i(port_m_i),
    .sts3_i  (sts3_i),
    .sfr_rd_i(sfr_rd_i),
    .data_o  (ld_data)
  );

  io_xfer_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .acc_i      (acc_i),
    .ld_data_i  (ld_data),
    .acc_we_o   (acc_we_o),
    .acc_wdata_o(acc_wdata_o),
    .sfr_we_o   (sfr_we_o),
    .sfr_wdata_o(sfr_wdata_o),
    .ctl3_o     (ctl3_o),
    .pd_s_en_o  (pd_s_en_o),
    .pd_m_en_o  (pd_m_en_o),
    .err_o      (err_o)
  );

endmodule

// File: rtl/io_xfer_dec_chk.sv
module io_xfer_dec_chk #(
  parameter int unsigned DW = 4,
  parameter int unsigned PTR_W = 4,
  parameter logic [PTR_W-1:0] CTL_PTR = 4'hD
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [7:0]       opcode_i,
  input logic             sel_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [DW-1:0]    acc_i,
  input logic [DW-1:0]    port_s_i,
  input logic [DW-1:0]    port_m_i,
  input logic [DW-1:0]    sts3_i,
  input logic [DW-1:0]    sfr_rd_i,
  input logic             acc_we_o,
  input logic [DW-1:0]    acc_wdata_o,
  input logic             sfr_we_o,
  input logic [DW-1:0]    sfr_wdata_o,
  input logic [DW-1:0]    ctl3_o,
  input logic             pd_s_en_o,
  input logic             pd_m_en_o,
  input logic             err_o
);

  p_ips_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hAF |=> acc_we_o && acc_wdata_o == $past(port_s_i));

  p_ipm_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hA8 |=> acc_we_o && acc_wdata_o == $past(port_m_i));

  p_pulldown_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:2] == 6'b111101 |=>
      pd_s_en_o == $past(opcode_i[0]) && pd_m_en_o == $past(opcode_i[1]));

  p_ctl3_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hFC && !sel_i && ptr_i == CTL_PTR |=>
      ctl3_o == $past(acc_i) && !sfr_we_o && !acc_we_o);

  p_sfr_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'hFC && sel_i |=>
      sfr_we_o && sfr_wdata_o == $past(acc_i) && $stable(ctl3_o));

  p_err_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !acc_we_o && !sfr_we_o && $stable(ctl3_o));

  p_single_action_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, sfr_we_o, err_o}));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !acc_we_o && !sfr_we_o && !err_o && $stable(ctl3_o)
                 && $stable(pd_s_en_o) && $stable(pd_m_en_o));

  p_quiet_bus_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_we_o -> acc_wdata_o == '0) && (!sfr_we_o -> sfr_wdata_o == '0));

endmodule

bind io_xfer_dec io_xfer_dec_chk #(.DW(DW), .PTR_W(PTR_W), .CTL_PTR(CTL_PTR)) chk_i (.*);

// File: tb/io_xfer_dec_tb_top.sv
module io_xfer_dec_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic       sel_i = 1'b0;
  logic [3:0] ptr_i = 4'h0;
  logic [3:0] acc_i = 4'h0;
  logic [3:0] port_s_i = 4'h0;
  logic [3:0] port_m_i = 4'h0;
  logic [3:0] sts3_i = 4'h0;
  logic [3:0] sfr_rd_i = 4'h0;
  logic       acc_we_o;
  logic [3:0] acc_wdata_o;
  logic       sfr_we_o;
  logic [3:0] sfr_wdata_o;
  logic [3:0] ctl3_o;
  logic       pd_s_en_o;
  logic       pd_m_en_o;
  logic       err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  m_ctl3 = 4'h0;
  logic        m_pds = 1'b0;
  logic        m_pdm = 1'b0;

  always #5 clk_i = ~clk_i;

  io_xfer_dec dut_i (.*);

  function automatic logic [16:0] pack_obs();
    return {acc_we_o, acc_wdata_o, sfr_we_o, sfr_wdata_o, err_o, ctl3_o, pd_s_en_o, pd_m_en_o};
  endfunction

  // Drive one instruction cycle and push what the requirements predict
  task automatic drv(input logic v, input logic [7:0] op, input logic s, input logic [3:0] p,
                     input logic [3:0] a, input logic [3:0] ps, input logic [3:0] pm,
                     input logic [3:0] st, input logic [3:0] sf, input string tag);
    logic aw, sw, er;
    logic [3:0] ad, sd;
    logic ok;
    @(negedge clk_i);
    valid_i = v; opcode_i = op; sel_i = s; ptr_i = p; acc_i = a;
    port_s_i = ps; port_m_i = pm; sts3_i = st; sfr_rd_i = sf;
    aw = 0; sw = 0; er = 0; ad = 0; sd = 0;
    ok = s || (p == 4'hD);
    if (v) begin
      if (op == 8'hAF) begin aw = 1; ad = ps; end
      else if (op == 8'hA8) begin aw = 1; ad = pm; end
      else if (op[7:2] == 6'b111101) begin m_pds = op[0]; m_pdm = op[1]; end
      else if (op == 8'h17) begin
        if (!ok) er = 1; else begin aw = 1; ad = s ? sf : st; end
      end else if (op == 8'hFC) begin
        if (!ok) er = 1; else if (s) begin sw = 1; sd = a; end else m_ctl3 = a;
      end else if (op == 8'h02) begin
        if (!ok) er = 1;
      end
    end
    exp_q.push_back({aw, ad, sw, sd, er, m_ctl3, m_pds, m_pdm});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk_i) begin
    #2;
    if (rst_ni && exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (pack_obs() !== e) begin
        n_bad++;
        $display("FAIL %s: actual %05h expected %05h", t, pack_obs(), e);
      end
    end
  end

  initial begin
    #3;
    n_cmp++;
    if (pack_obs() !== 17'h0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual %05h expected %05h", pack_obs(), 17'h0);
    end
    #20 rst_ni = 1'b1;

    drv(0, 8'h00, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R1 after reset");
    drv(1, 8'hAF, 0, 4'h0, 4'h0, 4'h5, 4'hA, 4'h0, 4'h0, "R2 port S 5");
    drv(1, 8'hAF, 1, 4'h3, 4'h0, 4'hA, 4'h1, 4'h0, 4'h0, "R2 port S A");
    drv(1, 8'hAF, 0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, "R2 port S F");
    drv(1, 8'hA8, 0, 4'h0, 4'h0, 4'h6, 4'h3, 4'h0, 4'h0, "R3 port M 3");
    drv(1, 8'hA8, 0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, "R3 port M 0 R11");
    drv(1, 8'hF5, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R4 S on M off");
    drv(1, 8'hF6, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R4 S off M on");
    drv(1, 8'hF7, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R4 both on");
    drv(1, 8'hF4, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R4 both off");
    drv(1, 8'h17, 0, 4'hD, 4'h0, 4'h1, 4'h2, 4'h9, 4'h4, "R5 IN status");
    drv(1, 8'hFC, 0, 4'hD, 4'h6, 4'h0, 4'h0, 4'h0, 4'h0, "R6 OUT ctl3");
    drv(1, 8'h17, 1, 4'h3, 4'h0, 4'h0, 4'h0, 4'h9, 4'hC, "R7 IN sfr");
    drv(1, 8'hFC, 1, 4'h0, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, "R7 OUT sfr");
    drv(1, 8'h17, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h9, 4'h0, "R8 IN ptr 0");
    drv(1, 8'h17, 0, 4'hC, 4'h0, 4'h0, 4'h0, 4'h9, 4'h0, "R8 IN ptr C");
    drv(1, 8'hFC, 0, 4'hE, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, "R8 OUT ptr E");
    drv(1, 8'hFC, 0, 4'hF, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R8 OUT ptr F");
    drv(1, 8'hFF, 0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, "R8 err drops R9 NOP");
    drv(1, 8'h02, 0, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R8 table write ptr 5");
    drv(1, 8'h02, 0, 4'hD, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R10 table write ptr D");
    drv(1, 8'h02, 1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R10 table write sel");
    drv(0, 8'hFC, 0, 4'hD, 4'h9, 4'h0, 4'h0, 4'h0, 4'h0, "R9 OUT without valid");
    drv(0, 8'hF7, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R9 pull-down without valid");
    drv(1, 8'h00, 0, 4'h0, 4'h5, 4'h3, 4'h3, 4'h3, 4'h3, "R9 unlisted opcode");
    drv(1, 8'hFC, 0, 4'hD, 4'hB, 4'h0, 4'h0, 4'h0, 4'h0, "R6 OUT ctl3 B");
    drv(0, 8'h00, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R9 idle");
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule